// File: doc/BRIEF.md
# Radio Time-Code Minute Frame Decoder

This block sits behind a pulse classifier that has already turned the one-per-second carrier dips into bit values. It gets a stream of classified bits, a strobe at the start of each minute (the classifier raises it at the first mark after the missing 59th-second mark), and fault events for timing problems the classifier finds itself. The block shifts the bits of one minute into a register. When the next minute-start strobe comes, it judges the whole frame.

The judgement covers four things. It counts the bits. It checks three even-parity groups. It converts the BCD fields for minute, hour, day of month, weekday, month and two-digit year to binary, and range-checks the results. It can also require that the frame is exactly one minute later than the previous good frame. A clean frame describes the minute that is starting. The block then puts that time on its outputs and raises `ready` for one cycle. Any failure sets an error flag and a coded error value, and adds one to a saturating error counter. All three clear on the next frame that passes the parity and range checks.

Top module: `tcf_decoder`

## Requirements
- R1: After synchronous reset, `ready` and `err` are 0, `err_code` is 0x000, `err_count` is 0, and every time field is 0.
- R2: Each cycle with `bit_valid` high appends `bit_value` to the frame. The k-th bit after a minute-start strobe is bit k, counted from 0. The first strobe after reset, or after a classifier fault, only synchronises: it changes no output.
- R3: Bit positions and weights, least significant bit first. Minute units are bits 21–24 and minute tens bits 25–27. Hour units are bits 29–32 and hour tens bits 33–34. Day units are bits 36–39 and day tens bits 40–41. Weekday is bits 42–44. Month units are bits 45–48 and the month tens bit is bit 49. Year units are bits 50–53 and year tens bits 54–57. A strobe that closes a clean 59-bit frame drives these values, converted to binary, onto the time outputs and raises `ready` in the next cycle.
- R4: `ready` is high for exactly one cycle per accepted frame. The time outputs change only in a cycle where `ready` is high.
- R5: Parity is even over three groups: bits 21–28, bits 29–35, and bits 36–58. If any group fails, the result is `err`=1, `err_code`=0x200 and no `ready`.
- R6: A frame with good parity fails the range check if any BCD digit is above 9, or if a value is outside these limits: minute 0–59, hour 0–23, day 1–31, weekday 1–7, month 1–12, year 0–99. Such a frame gives `err_code`=0x300 and no `ready`.
- R7: A strobe that closes a frame with fewer than 59 bits gives `err_code`=0x400. One that closes a frame with more than 59 bits gives 0x500.
- R8: Classifier fault codes on `cls_fault` map as follows: 1 gives 0x100, 2 gives 0x400 and 3 gives 0x500. The error is reported in the next cycle. The fault drops the partial frame and clears synchronisation.
- R9: Every error adds one to `err_count`, which saturates at its maximum. `err`, `err_code` and `err_count` all return to 0 on the next frame that passes both the parity and range checks.
- R10: While `seq_check_en` is 1, a clean frame raises `ready` only if it equals the previous clean frame plus one minute. A mismatch raises no error and becomes the new reference. Any error discards the reference.
- R11: The one-minute step carries minute 59 into the next hour, and 23:59 into 00:00. The date fields must stay unchanged, except across the 23:59 to 00:00 step, where they are not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_check_en | input | 1 | Require consecutive-minute agreement before ready |
| bit_valid | input | 1 | A classified bit is present this cycle |
| bit_value | input | 1 | Value of the classified bit |
| minute_start | input | 1 | One-cycle strobe at the start of a minute |
| cls_fault | input | 2 | Classifier fault event: 0 none, 1 timeout, 2 cycle too long, 3 cycle too short |
| ready | output | 1 | One-cycle pulse: time outputs hold a freshly accepted minute |
| minute | output | 6 | Decoded minute, binary |
| hour | output | 5 | Decoded hour, binary |
| day | output | 5 | Decoded day of month, binary |
| weekday | output | 3 | Decoded weekday, 1 to 7 |
| month | output | 4 | Decoded month, binary |
| year | output | 7 | Decoded two-digit year, binary |
| err | output | 1 | Error present since the last clean frame |
| err_code | output | 12 | Code of the most recent error (0x000 to 0x500) |
| err_count | output | CNT_W | Errors since the last clean frame, saturating |

## Verification
A bit counter or shift register that is off by one shows up at the very next minute strobe. The fields come out moved by one position, or the frame is reported as too long or too short. A broken parity group or range limit shows as a wrong `err_code`, or as a `ready` pulse where there should be none, on the strobe that closes the faulty frame. A stale consecutive-minute reference or a bad rollover rule shows one minute later, as a missing or extra `ready`. The bench compares every strobe and every fault event against a queue of expected results, one cycle after the event, and checks that `ready` has dropped and the time is held in the cycle after that.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    localparam int FRAME_BITS = 59;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] day;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] minute;
    } tcf_time_t;

    typedef enum logic [2:0] {
        EK_NONE    = 3'd0,
        EK_TIMEOUT = 3'd1,
        EK_PARITY  = 3'd2,
        EK_RANGE   = 3'd3,
        EK_LONG    = 3'd4,
        EK_SHORT   = 3'd5
    } tcf_err_e;

    typedef enum logic [1:0] {
        CF_NONE    = 2'd0,
        CF_TIMEOUT = 2'd1,
        CF_LONG    = 2'd2,
        CF_SHORT   = 2'd3
    } tcf_fault_e;

    function automatic logic digit_ok(input logic [3:0] d);
        return d <= 4'd9;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [3:0] tens, input logic [3:0] units);
        return ({4'd0, tens} * 8'd10) + {4'd0, units};
    endfunction

    function automatic logic wraps_midnight(input tcf_time_t t);
        return (t.minute == 6'd59) && (t.hour == 5'd23);
    endfunction

    function automatic tcf_time_t add_minute(input tcf_time_t t);
        tcf_time_t r;
        r = t;
        if (t.minute == 6'd59) begin
            r.minute = 6'd0;
            r.hour   = (t.hour == 5'd23) ? 5'd0 : t.hour + 5'd1;
        end else begin
            r.minute = t.minute + 6'd1;
        end
        return r;
    endfunction

    function automatic logic [11:0] err_to_code(input tcf_err_e k);
        return {1'b0, k, 8'h00};
    endfunction

endpackage

// File: rtl/tcf_collect.sv
module tcf_collect #(
    parameter int NBITS = 59,
    localparam int CW = $clog2(NBITS + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [NBITS-1:0] frame,
    output logic [CW-1:0]    count
);
    localparam logic [CW-1:0] CNT_SAT = CW'(NBITS + 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (shift_en && count != CNT_SAT) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
        end else if (shift_en) begin
            frame <= {bit_in, frame[NBITS-1:1]};
        end
    end
endmodule

// File: rtl/tcf_check.sv
module tcf_check
    import tcf_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame,
    output tcf_time_t             value,
    output logic                  parity_ok,
    output logic                  range_ok
);
    localparam int NGRP = 3;
    logic [NGRP-1:0] grp_bad;

    for (genvar g = 0; g < NGRP; g++) begin : g_par
        localparam int LO = (g == 0) ? 21 : (g == 1) ? 29 : 36;
        localparam int HI = (g == 0) ? 28 : (g == 1) ? 35 : 58;
        assign grp_bad[g] = ^frame[HI:LO];
    end

    logic unused_head;
    assign unused_head = ^frame[20:0];

    logic [3:0] mi_u, mi_t, hr_u, hr_t, dy_u, dy_t, mo_u, mo_t, yr_u, yr_t;
    logic [7:0] mi_b, hr_b, dy_b, mo_b, yr_b;
    logic [2:0] wd;

    always_comb begin
        mi_u = frame[24:21];
        mi_t = {1'b0, frame[27:25]};
        hr_u = frame[32:29];
        hr_t = {2'b0, frame[34:33]};
        dy_u = frame[39:36];
        dy_t = {2'b0, frame[41:40]};
        wd   = frame[44:42];
        mo_u = frame[48:45];
        mo_t = {3'b0, frame[49]};
        yr_u = frame[53:50];
        yr_t = frame[57:54];

        mi_b = bcd_to_bin(mi_t, mi_u);
        hr_b = bcd_to_bin(hr_t, hr_u);
        dy_b = bcd_to_bin(dy_t, dy_u);
        mo_b = bcd_to_bin(mo_t, mo_u);
        yr_b = bcd_to_bin(yr_t, yr_u);

        parity_ok = ~|grp_bad;

        range_ok = digit_ok(mi_u) && digit_ok(hr_u) && digit_ok(dy_u)
                && digit_ok(mo_u) && digit_ok(yr_u) && digit_ok(yr_t)
                && (mi_b <= 8'd59) && (hr_b <= 8'd23)
                && (dy_b >= 8'd1) && (dy_b <= 8'd31)
                && (wd != 3'd0)
                && (mo_b >= 8'd1) && (mo_b <= 8'd12)
                && (yr_b <= 8'd99);

        value.minute = mi_b[5:0];
        value.hour   = hr_b[4:0];
        value.day    = dy_b[4:0];
        value.wday   = wd;
        value.month  = mo_b[3:0];
        value.year   = yr_b[6:0];
    end
endmodule

// File: rtl/tcf_seq.sv
module tcf_seq
    import tcf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      drop,
    input  logic      load,
    input  tcf_time_t cur,
    output logic      follows
);
    tcf_time_t ref_q;
    logic      ref_valid;
    tcf_time_t nxt;
    logic      roll;
    logic      clock_eq, date_eq;

    always_ff @(posedge clk) begin
        if (rst || drop) begin
            ref_valid <= 1'b0;
            ref_q     <= '0;
        end else if (load) begin
            ref_valid <= 1'b1;
            ref_q     <= cur;
        end
    end

    always_comb begin
        nxt      = add_minute(ref_q);
        roll     = wraps_midnight(ref_q);
        clock_eq = (cur.minute == nxt.minute) && (cur.hour == nxt.hour);
        date_eq  = (cur.year == ref_q.year) && (cur.month == ref_q.month)
                && (cur.day == ref_q.day) && (cur.wday == ref_q.wday);
        follows  = ref_valid && clock_eq && (roll || date_eq);
    end
endmodule

// File: rtl/tcf_decoder.sv
module tcf_decoder
    import tcf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seq_check_en,
    input  logic             bit_valid,
    input  logic             bit_value,
    input  logic             minute_start,
    input  logic [1:0]       cls_fault,
    output logic             ready,
    output logic [5:0]       minute,
    output logic [4:0]       hour,
    output logic [4:0]       day,
    output logic [2:0]       weekday,
    output logic [3:0]       month,
    output logic [6:0]       year,
    output logic             err,
    output logic [11:0]      err_code,
    output logic [CNT_W-1:0] err_count
);
    localparam int CW = $clog2(FRAME_BITS + 2);
    localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                  fault_ev;
    logic                  synced;
    logic                  collect_clr;
    logic [FRAME_BITS-1:0] frame;
    logic [CW-1:0]         nbits;
    tcf_time_t             cand;
    tcf_time_t             shown;
    logic                  par_ok, rng_ok, follows;
    logic                  judge, frame_clean, frame_bad;
    tcf_err_e              kind_q, judge_kind, fault_kind;

    assign fault_ev    = (cls_fault != CF_NONE);
    assign collect_clr = fault_ev || minute_start;
    assign judge       = minute_start && !fault_ev && synced;

    tcf_collect #(.NBITS(FRAME_BITS)) u_collect (
        .clk      (clk),
        .rst      (rst),
        .clear    (collect_clr),
        .shift_en (bit_valid && !collect_clr),
        .bit_in   (bit_value),
        .frame    (frame),
        .count    (nbits)
    );

    tcf_check u_check (
        .frame     (frame),
        .value     (cand),
        .parity_ok (par_ok),
        .range_ok  (rng_ok)
    );

    always_comb begin
        if (nbits < FULL)       judge_kind = EK_LONG;
        else if (nbits > FULL)  judge_kind = EK_SHORT;
        else if (!par_ok)       judge_kind = EK_PARITY;
        else if (!rng_ok)       judge_kind = EK_RANGE;
        else                    judge_kind = EK_NONE;

        case (tcf_fault_e'(cls_fault))
            CF_TIMEOUT: fault_kind = EK_TIMEOUT;
            CF_LONG:    fault_kind = EK_LONG;
            CF_SHORT:   fault_kind = EK_SHORT;
            default:    fault_kind = EK_NONE;
        endcase

        frame_clean = judge && (judge_kind == EK_NONE);
        frame_bad   = judge && (judge_kind != EK_NONE);
    end

    tcf_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .drop    (fault_ev || frame_bad),
        .load    (frame_clean),
        .cur     (cand),
        .follows (follows)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            synced    <= 1'b0;
            ready     <= 1'b0;
            err       <= 1'b0;
            kind_q    <= EK_NONE;
            err_count <= '0;
            shown     <= '0;
        end else begin
            ready <= 1'b0;
            if (fault_ev) begin
                synced <= 1'b0;
                err    <= 1'b1;
                kind_q <= fault_kind;
                if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
            end else if (minute_start) begin
                synced <= 1'b1;
                if (frame_bad) begin
                    err    <= 1'b1;
                    kind_q <= judge_kind;
                    if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
                end else if (frame_clean) begin
                    err       <= 1'b0;
                    kind_q    <= EK_NONE;
                    err_count <= '0;
                    if (!seq_check_en || follows) begin
                        ready <= 1'b1;
                        shown <= cand;
                    end
                end
            end
        end
    end

    assign err_code = err_to_code(kind_q);
    assign minute   = shown.minute;
    assign hour     = shown.hour;
    assign day      = shown.day;
    assign weekday  = shown.wday;
    assign month    = shown.month;
    assign year     = shown.year;
endmodule

// File: rtl/tcf_decoder_chk.sv
module tcf_decoder_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             minute_start,
    input logic             ready,
    input logic [5:0]       minute,
    input logic [4:0]       hour,
    input logic [4:0]       day,
    input logic [2:0]       weekday,
    input logic [3:0]       month,
    input logic [6:0]       year,
    input logic             err,
    input logic [11:0]      err_code,
    input logic [CNT_W-1:0] err_count
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready); // R4

    AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ready |-> $past(minute_start)); // R3

    AST_TIME_HELD: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !ready |-> ($stable(minute) && $stable(hour) && $stable(day)
                    && $stable(weekday) && $stable(month) && $stable(year))); // R4

    AST_READY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!err && err_code == 12'h000 && err_count == '0)); // R9

    AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        err == (err_code != 12'h000)); // R5

    AST_READY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ready |-> (minute <= 6'd59 && hour <= 5'd23 && day >= 5'd1 && day <= 5'd31
                   && weekday != 3'd0 && month >= 4'd1 && month <= 4'd12
                   && year <= 7'd99)); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (err_count != $past(err_count)) |->
            (err_count == '0 || err_count == $past(err_count) + 1'b1)); // R9
endmodule

bind tcf_decoder tcf_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .minute_start (minute_start),
    .ready        (ready),
    .minute       (minute),
    .hour         (hour),
    .day          (day),
    .weekday      (weekday),
    .month        (month),
    .year         (year),
    .err          (err),
    .err_code     (err_code),
    .err_count    (err_count)
);

// File: tb/tcf_decoder_bench.sv
module tcf_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             seq_check_en = 1'b0;
    logic             bit_valid = 1'b0;
    logic             bit_value = 1'b0;
    logic             minute_start = 1'b0;
    logic [1:0]       cls_fault = 2'd0;
    logic             ready;
    logic [5:0]       minute;
    logic [4:0]       hour;
    logic [4:0]       day;
    logic [2:0]       weekday;
    logic [3:0]       month;
    logic [6:0]       year;
    logic             err;
    logic [11:0]      err_code;
    logic [CNT_W-1:0] err_count;

    tcf_decoder #(.CNT_W(CNT_W)) u_tcf_decoder (
        .clk(clk), .rst(rst), .seq_check_en(seq_check_en),
        .bit_valid(bit_valid), .bit_value(bit_value),
        .minute_start(minute_start), .cls_fault(cls_fault),
        .ready(ready), .minute(minute), .hour(hour), .day(day),
        .weekday(weekday), .month(month), .year(year),
        .err(err), .err_code(err_code), .err_count(err_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        rdy;
        logic [11:0] code;
        int          cnt;
        logic [29:0] tm;   // {year,month,day,wday,hour,minute}
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [29:0] held = '0;
    bit          done = 0;

    function automatic logic [29:0] outs();
        return {year, month, day, weekday, hour, minute};
    endfunction

    function automatic logic [29:0] tpack(int yr, int mo, int dy, int wd, int hr, int mi);
        return {7'(yr), 4'(mo), 5'(dy), 3'(wd), 5'(hr), 6'(mi)};
    endfunction

    // BCD arguments: upper nibble tens, lower nibble units
    function automatic logic [58:0] mk(logic [7:0] mi, logic [7:0] hr, logic [7:0] dy,
                                       logic [2:0] wd, logic [7:0] mo, logic [7:0] yr);
        logic [58:0] f;
        f = '0;
        f[20]    = 1'b1;
        f[27:21] = mi[6:0];
        f[28]    = ^mi[6:0];
        f[34:29] = hr[5:0];
        f[35]    = ^hr[5:0];
        f[41:36] = dy[5:0];
        f[44:42] = wd;
        f[49:45] = mo[4:0];
        f[57:50] = yr;
        f[58]    = ^f[57:36];
        return f;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic expect_ev(bit rdy, logic [11:0] code, int cnt, logic [29:0] tm, string tag);
        exp_t e;
        if (rdy) held = tm;
        e.rdy = rdy; e.code = code; e.cnt = cnt; e.tm = held; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic send_bits(logic [58:0] f, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_value = (i < 59) ? f[i] : 1'b0;
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic strobe();
        @(negedge clk); minute_start = 1'b1;
        @(negedge clk); minute_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic fault(logic [1:0] k);
        @(negedge clk); cls_fault = k;
        @(negedge clk); cls_fault = 2'd0;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame_ev(logic [58:0] f, int n, bit rdy, logic [11:0] code, int cnt,
                            logic [29:0] tm, string tag);
        send_bits(f, n);
        expect_ev(rdy, code, cnt, tm, tag);
        strobe();
    endtask

    // monitor: compares one cycle after each event, then checks ready drop (R4)
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && (minute_start || cls_fault != 2'd0)) begin
                exp_t e;
                logic [29:0] snap;
                #1;
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected event", 0, 0);
                end else begin
                    e = sb.pop_front();
                    check(ready == e.rdy, e.tag, "ready", 32'(ready), 32'(e.rdy));
                    check(err_code == e.code, e.tag, "err_code", 32'(err_code), 32'(e.code));
                    check(err == (e.code != 0), e.tag, "err", 32'(err), 32'(e.code != 0));
                    check(int'(err_count) == e.cnt, e.tag, "err_count", 32'(err_count), 32'(e.cnt));
                    check(outs() == e.tm, e.tag, "time", 32'(outs()), 32'(e.tm));
                end
                snap = outs();
                @(posedge clk); #1;
                check(ready == 1'b0, "R4", "ready second cycle", 32'(ready), 0);
                check(outs() == snap, "R4", "time hold", 32'(outs()), 32'(snap));
            end
        end
    end

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [58:0] f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ready == 0, "R1", "ready", 32'(ready), 0);
        check(err == 0, "R1", "err", 32'(err), 0);
        check(err_code == 0, "R1", "err_code", 32'(err_code), 0);
        check(err_count == 0, "R1", "err_count", 32'(err_count), 0);
        check(outs() == 0, "R1", "time", 32'(outs()), 0);

        // R2 first strobe only synchronises
        expect_ev(0, 12'h000, 0, 0, "R2");
        strobe();

        // R3 good frame 12:34, day 15, weekday 3, month 6, year 24
        frame_ev(mk(8'h34, 8'h12, 8'h15, 3'd3, 8'h06, 8'h24), 59, 1, 12'h000, 0,
                 tpack(24, 6, 15, 3, 12, 34), "R3");

        // R5 parity failures in each group
        f = mk(8'h35, 8'h12, 8'h15, 3'd3, 8'h06, 8'h24); f[22] = ~f[22];
        frame_ev(f, 59, 0, 12'h200, 1, 0, "R5");
        f = mk(8'h36, 8'h12, 8'h15, 3'd3, 8'h06, 8'h24); f[30] = ~f[30];
        frame_ev(f, 59, 0, 12'h200, 2, 0, "R5");
        f = mk(8'h37, 8'h12, 8'h15, 3'd3, 8'h06, 8'h24); f[50] = ~f[50];
        frame_ev(f, 59, 0, 12'h200, 3, 0, "R5");

        // R6 range: month 13, minute digit 0xA, weekday 0
        frame_ev(mk(8'h38, 8'h12, 8'h15, 3'd3, 8'h13, 8'h24), 59, 0, 12'h300, 4, 0, "R6");
        frame_ev(mk(8'h1A, 8'h12, 8'h15, 3'd3, 8'h06, 8'h24), 59, 0, 12'h300, 5, 0, "R6");
        frame_ev(mk(8'h39, 8'h12, 8'h15, 3'd0, 8'h06, 8'h24), 59, 0, 12'h300, 6, 0, "R6");

        // R9 clean frame at upper bounds clears errors
        frame_ev(mk(8'h59, 8'h23, 8'h31, 3'd7, 8'h12, 8'h99), 59, 1, 12'h000, 0,
                 tpack(99, 12, 31, 7, 23, 59), "R9");

        // R7 short and long frames
        f = mk(8'h01, 8'h00, 8'h01, 3'd1, 8'h01, 8'h00);
        frame_ev(f, 58, 0, 12'h400, 1, 0, "R7");
        frame_ev(f, 60, 0, 12'h500, 2, 0, "R7");

        // R8 classifier faults, then resync strobe changes nothing
        expect_ev(0, 12'h100, 3, 0, "R8"); fault(2'd1);
        expect_ev(0, 12'h400, 4, 0, "R8"); fault(2'd2);
        expect_ev(0, 12'h500, 5, 0, "R8"); fault(2'd3);
        expect_ev(0, 12'h500, 5, 0, "R8"); strobe();
        frame_ev(mk(8'h00, 8'h00, 8'h01, 3'd1, 8'h01, 8'h25), 59, 1, 12'h000, 0,
                 tpack(25, 1, 1, 1, 0, 0), "R9");

        // R10 consecutive-minute check
        @(negedge clk); seq_check_en = 1'b1;
        frame_ev(mk(8'h00, 8'h10, 8'h01, 3'd1, 8'h01, 8'h25), 59, 0, 12'h000, 0, 0, "R10");
        frame_ev(mk(8'h01, 8'h10, 8'h01, 3'd1, 8'h01, 8'h25), 59, 1, 12'h000, 0,
                 tpack(25, 1, 1, 1, 10, 1), "R10");
        frame_ev(mk(8'h03, 8'h10, 8'h01, 3'd1, 8'h01, 8'h25), 59, 0, 12'h000, 0, 0, "R10");
        frame_ev(mk(8'h04, 8'h10, 8'h01, 3'd1, 8'h01, 8'h25), 59, 1, 12'h000, 0,
                 tpack(25, 1, 1, 1, 10, 4), "R10");

        // R11 hour and midnight rollover, and date change off midnight
        frame_ev(mk(8'h59, 8'h10, 8'h01, 3'd1, 8'h01, 8'h25), 59, 0, 12'h000, 0, 0, "R11");
        frame_ev(mk(8'h00, 8'h11, 8'h01, 3'd1, 8'h01, 8'h25), 59, 1, 12'h000, 0,
                 tpack(25, 1, 1, 1, 11, 0), "R11");
        frame_ev(mk(8'h59, 8'h23, 8'h05, 3'd5, 8'h01, 8'h25), 59, 0, 12'h000, 0, 0, "R11");
        frame_ev(mk(8'h00, 8'h00, 8'h06, 3'd6, 8'h01, 8'h25), 59, 1, 12'h000, 0,
                 tpack(25, 1, 6, 6, 0, 0), "R11");
        frame_ev(mk(8'h01, 8'h00, 8'h07, 3'd7, 8'h01, 8'h25), 59, 0, 12'h000, 0, 0, "R11");

        // R10 an error discards the reference
        frame_ev(mk(8'h02, 8'h00, 8'h07, 3'd7, 8'h01, 8'h25), 57, 0, 12'h400, 1, 0, "R10");
        frame_ev(mk(8'h03, 8'h00, 8'h07, 3'd7, 8'h01, 8'h25), 59, 0, 12'h000, 0, 0, "R10");

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R2", "pending events", 32'(sb.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule